// File: doc/BRIEF.md
# Prioritized Multi-Converter Interrupt Servicer

This block sits between a bank of up to seven data converters and a small result buffer. Each converter reports that it has finished by pulling its own completion line low. While no service pass is running and any line is low, the block raises an interrupt. When the host acknowledges, the block freezes the completion lines into a status snapshot and starts a service pass.

During the pass, it visits the flagged channels one at a time, always the lowest channel number first. For each channel it pulses that channel's read strobe for one cycle and takes the byte from the shared data bus on the next cycle. It then stores two bytes in the result buffer: the data byte, and directly above it an identifier byte naming the source channel. The write pointer moves on by two for every serviced channel and wraps around the buffer.

Channels that finish after the snapshot has been taken wait for the next interrupt.

Top module: `conv_irq_servicer`

## Requirements
- R1: `irq_o` is high exactly when at least one bit of `done_ni` is low and no service pass is running. It is low after reset and stays low for the whole of a pass.
- R2: An `ack_i` seen while idle captures `~done_ni` into the snapshot and starts a pass. An `ack_i` seen during a pass has no effect on that pass.
- R3: Only channels whose bit is set in the snapshot are read. `rd_o` carries at most one set bit, and each strobe lasts exactly one cycle.
- R4: Within a pass, channels are read in ascending order, so bit 0 (channel 1) comes first and bit 6 (channel 7) comes last.
- R5: The bus value present in the cycle after a strobe is written to the buffer at the current pointer. This write happens in the second cycle after the strobe cycle.
- R6: In the cycle after a data write, the identifier byte is written at the pointer plus one. The identifier equals the channel number, which is the bit index plus 1, in the range 1 to 7.
- R7: The pointer is 0 after reset. It advances by 2 for each serviced channel and wraps modulo the buffer depth (16).
- R8: A completion that arrives during a pass is not read in that pass. It raises `irq_o` once the pass ends.
- R9: An acknowledge while every completion line is high causes no strobe and no buffer write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| done_ni | input | 7 | Active-low completion line, one per converter; bit k is channel k+1 |
| irq_o | output | 1 | Service request to the host |
| ack_i | input | 1 | Host acknowledge; starts a pass when idle |
| rd_o | output | 7 | One-cycle read strobe for each converter |
| bus_i | input | 8 | Shared converter data bus |
| buf_addr_o | output | 4 | Result buffer write address |
| buf_data_o | output | 8 | Result buffer write data |
| buf_we_o | output | 1 | Result buffer write enable |

## Verification
The assertions check the following on every cycle:
- Strobes are one-hot and last a single cycle.
- Within a pass, strobes move strictly upward in channel order.
- Each strobe is followed by a data write two cycles later, and then an identifier write in the range 1 to 7 at the next address.
- The interrupt stays low while a strobe is active.
- The pointer steps by two.

Some behaviours can only be shown by the bench's scenarios, because they depend on the converters and on exact buffer contents:
- Which channels were actually flagged.
- That bus values land at the right addresses.
- That the pointer wraps across passes.
- That late completions and mid-pass acknowledges are deferred to the next pass.

// File: rtl/conv_srv_pkg.sv
package conv_srv_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SCAN,
    ST_STROBE,
    ST_DATA,
    ST_ID
  } srv_state_e;
endpackage

// File: rtl/srv_prio_pick.sv
module srv_prio_pick #(
  parameter int N  = 7,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  output logic          valid_o,
  output logic [N-1:0]  onehot_o,
  output logic [IW-1:0] idx_o
);
  logic [N-1:0] below;

  assign below[0] = 1'b0;
  for (genvar i = 1; i < N; i++) begin : g_below
    assign below[i] = below[i-1] | req_i[i-1];
  end

  assign onehot_o = req_i & ~below;
  assign valid_o  = |req_i;

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (onehot_o[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/srv_wr_ptr.sv
module srv_wr_ptr #(
  parameter int AW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adv_i,
  output logic [AW-1:0] ptr_o
);
  logic [AW-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_q <= '0;
    else if (adv_i) ptr_q <= ptr_q + AW'(2);
  end

  assign ptr_o = ptr_q;

  // R7: two slots per serviced channel, modulo depth
  p_ptr_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |=> ptr_o == $past(ptr_o) + AW'(2));
  p_ptr_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(ptr_o));
endmodule

// File: rtl/conv_irq_servicer.sv
module conv_irq_servicer
  import conv_srv_pkg::*;
#(
  parameter int NUM_CH = 7,
  parameter int DW     = 8,
  parameter int BUF_AW = 4,
  localparam int IW    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] done_ni,
  output logic              irq_o,
  input  logic              ack_i,
  output logic [NUM_CH-1:0] rd_o,
  input  logic [DW-1:0]     bus_i,
  output logic [BUF_AW-1:0] buf_addr_o,
  output logic [DW-1:0]     buf_data_o,
  output logic              buf_we_o
);
  srv_state_e        state_q;
  logic [NUM_CH-1:0] snap_q;
  logic [NUM_CH-1:0] rd_q;
  logic [IW-1:0]     cur_q;
  logic              we_q;
  logic [BUF_AW-1:0] addr_q;
  logic [DW-1:0]     data_q;

  logic              pick_valid;
  logic [NUM_CH-1:0] pick_onehot;
  logic [IW-1:0]     pick_idx;
  logic [BUF_AW-1:0] ptr;
  logic              ptr_adv;

  srv_prio_pick #(.N(NUM_CH)) u_pick (
    .req_i    (snap_q),
    .valid_o  (pick_valid),
    .onehot_o (pick_onehot),
    .idx_o    (pick_idx)
  );

  assign ptr_adv = (state_q == ST_ID);

  srv_wr_ptr #(.AW(BUF_AW)) u_ptr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (ptr_adv),
    .ptr_o  (ptr)
  );

  assign irq_o = (state_q == ST_IDLE) && (|(~done_ni));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      snap_q  <= '0;
      rd_q    <= '0;
      cur_q   <= '0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      rd_q <= '0;
      we_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (ack_i) begin
            snap_q  <= ~done_ni;  // frozen; later completions wait
            state_q <= ST_SCAN;
          end
        end
        ST_SCAN: begin
          if (pick_valid) begin
            rd_q    <= pick_onehot;
            cur_q   <= pick_idx;
            snap_q  <= snap_q & ~pick_onehot;
            state_q <= ST_STROBE;
          end else begin
            state_q <= ST_IDLE;
          end
        end
        ST_STROBE: state_q <= ST_DATA;  // converter drives bus now
        ST_DATA: begin
          we_q    <= 1'b1;
          addr_q  <= ptr;
          data_q  <= bus_i;
          state_q <= ST_ID;
        end
        ST_ID: begin
          we_q    <= 1'b1;
          addr_q  <= ptr + BUF_AW'(1);
          data_q  <= DW'(cur_q) + DW'(1);
          state_q <= ST_SCAN;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rd_o       = rd_q;
  assign buf_we_o   = we_q;
  assign buf_addr_o = addr_q;
  assign buf_data_o = data_q;

  // checker state: last strobe in the current pass
  logic [NUM_CH-1:0] prev_rd_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          prev_rd_q <= '0;
    else if (state_q == ST_IDLE && ack_i) prev_rd_q <= '0;
    else if (rd_o != '0)                  prev_rd_q <= rd_o;
  end

  p_rd_onehot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rd_o));
  p_rd_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_o != '0) |=> (rd_o == '0));
  p_prio_order_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_o != '0 && prev_rd_q != '0) |-> (rd_o > prev_rd_q));
  p_irq_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_o != '0) |-> !irq_o);
  p_rd_to_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_o != '0) |=> !buf_we_o ##1 buf_we_o);
  p_id_follows_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (buf_we_o && !$past(buf_we_o)) |=>
      (buf_we_o && buf_addr_o == $past(buf_addr_o) + BUF_AW'(1)));
  p_id_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (buf_we_o && $past(buf_we_o)) |->
      (buf_data_o >= DW'(1) && buf_data_o <= DW'(NUM_CH)));
endmodule

// File: tb/conv_irq_servicer_bench.sv
module conv_irq_servicer_bench;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int NCH   = 7;
  localparam int DEPTH = 16;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NCH-1:0] done_n;
  logic           irq;
  logic           ack = 1'b0;
  logic [NCH-1:0] rd;
  logic [7:0]     bus = 8'h00;
  logic [3:0]     baddr;
  logic [7:0]     bdata;
  logic           bwe;

  always #2.5 clk = ~clk;

  conv_irq_servicer u_conv_irq_servicer (
    .clk_i(clk), .rst_ni(rst_n), .done_ni(done_n), .irq_o(irq), .ack_i(ack),
    .rd_o(rd), .bus_i(bus), .buf_addr_o(baddr), .buf_data_o(bdata), .buf_we_o(bwe)
  );

  // converter model: pending while start count differs from read count
  logic [7:0] val       [NCH];
  logic [7:0] start_tok [NCH];
  logic [7:0] rd_tok    [NCH];
  int         spurious_rd = 0;
  logic [11:0] wlog [$];

  always_comb
    for (int k = 0; k < NCH; k++) done_n[k] = (start_tok[k] == rd_tok[k]);

  initial for (int k = 0; k < NCH; k++) rd_tok[k] = 8'd0;

  always @(posedge clk) begin
    for (int k = 0; k < NCH; k++) begin
      if (rd[k]) begin
        if (start_tok[k] == rd_tok[k]) spurious_rd <= spurious_rd + 1;
        bus       <= val[k];
        rd_tok[k] <= rd_tok[k] + 8'd1;
      end
    end
    if (bwe) wlog.push_back({baddr, bdata});
  end

  int n_chk = 0, n_bad = 0, cycles = 0;
  int exp_ptr = 0;
  bit done_flag = 0;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 150000 && !done_flag) begin
      $display("FAIL watchdog: act=timeout exp=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad + 1);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic start_ch(input int k, input logic [7:0] v);
    @(negedge clk);
    val[k]       = v;
    start_tok[k] = start_tok[k] + 8'd1;
  endtask

  task automatic pulse_ack();
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // expected writes for a snapshot, data then identifier, lowest channel first
  task automatic compare_pass(input logic [NCH-1:0] mask, input string req);
    logic [11:0] exp_q [$];
    for (int k = 0; k < NCH; k++) begin
      if (mask[k]) begin
        exp_q.push_back({4'(exp_ptr), val[k]});
        exp_q.push_back({4'(exp_ptr + 1), 8'(k + 1)});
        exp_ptr = (exp_ptr + 2) % DEPTH;
      end
    end
    check(wlog.size() == exp_q.size(), req, wlog.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < wlog.size(); i++)
      check(wlog[i] == exp_q[i], req, int'(wlog[i]), int'(exp_q[i]));
    wlog.delete();
  endtask

  initial begin
    for (int k = 0; k < NCH; k++) begin
      start_tok[k] = 8'd0;
      val[k] = 8'd0;
    end
    void'($urandom(32'd4242));
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(1);
    // reset state (R1, R3, R7)
    check(irq == 1'b0, "R1 reset irq", irq, 0);
    check(rd == '0, "R3 reset rd", rd, 0);
    check(bwe == 1'b0, "R7 reset we", bwe, 0);

    // R9: acknowledge with nothing pending
    pulse_ack();
    wait_cyc(10);
    check(wlog.size() == 0, "R9 empty ack writes", wlog.size(), 0);
    check(spurious_rd == 0, "R9 no strobe", spurious_rd, 0);

    // R4, R5, R6, R7: all seven started in reverse order
    for (int k = NCH - 1; k >= 0; k--) start_ch(k, 8'hA0 + 8'(k));
    wait_cyc(1);
    check(irq == 1'b1, "R1 irq pending", irq, 1);
    pulse_ack();
    check(irq == 1'b0, "R1 irq in pass", irq, 0);
    wait_cyc(40);
    compare_pass(7'h7F, "R4 full pass");

    // R2, R8: late completion and acknowledge during a pass
    start_ch(4, 8'h55);
    start_ch(1, 8'h22);
    pulse_ack();
    wait_cyc(2);
    start_ch(0, 8'h11);
    wait_cyc(1);
    check(irq == 1'b0, "R1 irq low mid pass", irq, 0);
    pulse_ack();
    wait_cyc(30);
    compare_pass(7'b0010010, "R8 late excluded");
    check(irq == 1'b1, "R8 late raises irq", irq, 1);
    pulse_ack();
    wait_cyc(20);
    compare_pass(7'b0000001, "R2 next pass");
    check(irq == 1'b0, "R1 idle clear", irq, 0);

    // random passes, random start order and spacing (R3..R7)
    for (int it = 0; it < 24; it++) begin
      logic [NCH-1:0] m;
      int off;
      m   = 7'($urandom % 128);
      off = $urandom % NCH;
      for (int j = 0; j < NCH; j++) begin
        int k;
        k = (j + off) % NCH;
        if (m[k]) begin
          start_ch(k, 8'($urandom));
          wait_cyc($urandom % 3);
        end
      end
      wait_cyc(1);
      check(irq == (m != 0), "R1 random irq", irq, int'(m != 0));
      pulse_ack();
      wait_cyc(40);
      compare_pass(m, "R5 random pass");
    end
    check(spurious_rd == 0, "R3 only flagged read", spurious_rd, 0);

    done_flag = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule